// File: doc/BRIEF.md
# Debug Memory-Access Program Builder

This block serves the memory-access command of a debug module for a RISC-V style hart that has stopped in debug mode. A command selects an access width, a direction (load from or store to memory), an optional address post-increment and a virtual-address flag. The block checks the command against the hart state and its register width. If the command is legal, it writes a short program, one 32-bit instruction per cycle, into the small instruction buffer that the halted hart runs next.

The program keeps two scratch registers safe around the access. The data value is exchanged with the first argument word of the debug data area. The target address is held in the second argument word. With post-increment, the advanced address is written back into the second argument, so a debugger can stream through memory with repeated commands. Once the last instruction is written, the block pulses `seq_done` and raises the go and busy flags. An external completion signal drops both flags.

Top module: `absmem_seq_gen`

## Requirements
- R1: After reset no buffer write occurs, `seq_done`, `busy` and `go` are low, and `cmderr` is 0 (none).
- R2: A command accepted while `hart_halted` is low sets `cmderr` to 4 (halt/resume error) and writes nothing. This check takes priority over every other check.
- R3: A command from a halted hart sets `cmderr` to 2 (not supported) and writes nothing in any of these cases: the virtual bit is set, `cmd_size` is above 3, `cmd_size` is above log2(XLEN/8), or `xlen_code` is not 1 or 2.
- R4: Every program starts with `csrw dscratch0(0x7b2), s0(x8)` and `csrw dscratch1(0x7b3), s1(x9)`. It ends with `csrr s0, 0x7b2`, `csrr s1, 0x7b3` and `ebreak` (0x00100073).
- R5: A read program loads argument 1 into s0, loads from address [s0] into s0 at the command width, then stores s0 to argument 0 at XLEN width.
- R6: A write program loads argument 0 into s0 and argument 1 into s1, then stores s0 to address [s1] at the command width.
- R7: With post-increment, the access is followed by three instructions: load argument 1 into s1, `addi s1, s1, 1<<cmd_size`, and store s1 back to argument 1 at XLEN width.
- R8: Argument k is located at offset DATA_BASE + k*XLEN/8 from x0. The load/store funct3 is 0, 1, 2 or 3 for widths of 1, 2, 4 or 8 bytes. XLEN-width accesses use funct3 2 for XLEN 32 and 3 for XLEN 64.
- R9: Buffer writes occupy consecutive cycles, starting in the cycle after acceptance at index 0 and rising by one per cycle. A program is 8 words long, or 11 words with post-increment.
- R10: In the cycle after the last word, `seq_done` is high for exactly one cycle. `busy` and `go` are high from that cycle on, and `cmderr` is 0.
- R11: `cmd_valid` is ignored while a program is being written or while `busy` is high. `exec_done` clears `busy` and `go`.
- R12: `xlen_code` 1 selects XLEN 32 and 2 selects XLEN 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_size | input | 3 | Access width as log2(bytes) |
| cmd_postinc | input | 1 | Advance the address after the access |
| cmd_virtual | input | 1 | Virtual-address request (always rejected) |
| cmd_write | input | 1 | 1 = store to memory, 0 = load from memory |
| hart_halted | input | 1 | The selected hart is halted |
| xlen_code | input | 2 | Hart register width, 1 = 32, 2 = 64 |
| exec_done | input | 1 | The hart has finished running the program |
| buf_we | output | 1 | Instruction buffer write enable |
| buf_idx | output | 4 | Instruction buffer word index |
| buf_wdata | output | 32 | Instruction word |
| seq_done | output | 1 | One-cycle pulse after the last word |
| busy | output | 1 | Command outstanding |
| go | output | 1 | Request to the hart to run the buffer |
| cmderr | output | 3 | Error code: 0 none, 2 not supported, 4 halt/resume |

## Verification
The hardest case to reach is a command that arrives while the previous program is still outstanding. It is hard to reach because acceptance would overwrite the error code and restart the buffer. The bench raises `cmd_valid` during the busy window with `hart_halted` low, so a wrongly accepted command would show up at once as a halt/resume error or as a new buffer write. The width-legality boundary is reached by pairing size 3 with both register widths. The bench also sends a command that breaks two rules at once to confirm that the halt check wins.

// File: rtl/absmem_pkg.sv
package absmem_pkg;

  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_NOTSUP  = 3'd2,
    ERR_HALTRES = 3'd4
  } err_e;

  localparam int SEQ_MAX = 11;
  localparam int STEP_W  = $clog2(SEQ_MAX + 1);

  localparam logic [4:0]  RX_ZERO = 5'd0;
  localparam logic [4:0]  RX_S0   = 5'd8;
  localparam logic [4:0]  RX_S1   = 5'd9;
  localparam logic [11:0] CSR_SCR0 = 12'h7b2;
  localparam logic [11:0] CSR_SCR1 = 12'h7b3;
  localparam logic [31:0] OP_EBREAK = 32'h0010_0073;

  function automatic logic [31:0] enc_load(logic [4:0] rd, logic [4:0] rs1,
                                           logic [11:0] imm, logic [2:0] f3);
    return {imm, rs1, f3, rd, 7'b0000011};
  endfunction

  function automatic logic [31:0] enc_store(logic [4:0] rs2, logic [4:0] rs1,
                                            logic [11:0] imm, logic [2:0] f3);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], 7'b0100011};
  endfunction

  function automatic logic [31:0] enc_addi(logic [4:0] rd, logic [4:0] rs1,
                                           logic [11:0] imm);
    return {imm, rs1, 3'b000, rd, 7'b0010011};
  endfunction

  function automatic logic [31:0] enc_csrw(logic [11:0] csr, logic [4:0] rs);
    return {csr, rs, 3'b001, 5'd0, 7'b1110011};
  endfunction

  function automatic logic [31:0] enc_csrr(logic [4:0] rd, logic [11:0] csr);
    return {csr, 5'd0, 3'b010, rd, 7'b1110011};
  endfunction

endpackage

// File: rtl/absmem_check.sv
module absmem_check
  import absmem_pkg::*;
(
  input  logic       halted,
  input  logic       virt,
  input  logic [2:0] size,
  input  logic [1:0] xlen_code,
  output err_e       err,
  output logic [1:0] xlen_log
);
  logic xlen_ok;
  logic too_wide;

  always_comb begin
    xlen_ok  = (xlen_code == 2'd1) || (xlen_code == 2'd2);
    xlen_log = (xlen_code == 2'd2) ? 2'd3 : 2'd2;
    too_wide = (size > 3'd3) || (size > {1'b0, xlen_log});
    if (!halted)
      err = ERR_HALTRES;
    else if (virt || !xlen_ok || too_wide)
      err = ERR_NOTSUP;
    else
      err = ERR_NONE;
  end
endmodule

// File: rtl/absmem_encoder.sv
module absmem_encoder
  import absmem_pkg::*;
#(
  parameter logic [11:0] DATA_BASE = 12'h380
) (
  input  logic [STEP_W-1:0] step,
  input  logic              is_write,
  input  logic              postinc,
  input  logic [1:0]        size,
  input  logic [1:0]        xlen_log,
  output logic [31:0]       word
);
  localparam logic [STEP_W-1:0] BODY_AT = STEP_W'(2);
  localparam logic [STEP_W-1:0] INC_AT  = STEP_W'(5);
  localparam logic [STEP_W-1:0] TAIL_NI = STEP_W'(5);
  localparam logic [STEP_W-1:0] TAIL_PI = STEP_W'(8);

  logic [11:0]       arg0, arg1;
  logic [2:0]        xf3, sf3;
  logic [STEP_W-1:0] tail_at;
  logic [STEP_W-1:0] rel;

  always_comb begin
    arg0    = DATA_BASE;
    arg1    = DATA_BASE + (12'd1 << xlen_log);
    xf3     = {1'b0, xlen_log};
    sf3     = {1'b0, size};
    tail_at = postinc ? TAIL_PI : TAIL_NI;
    rel     = '0;
    word    = OP_EBREAK;
    if (step == STEP_W'(0)) begin
      word = enc_csrw(CSR_SCR0, RX_S0);
    end else if (step == STEP_W'(1)) begin
      word = enc_csrw(CSR_SCR1, RX_S1);
    end else if (step < INC_AT) begin
      rel = step - BODY_AT;
      if (is_write) begin
        case (rel)
          STEP_W'(0): word = enc_load(RX_S0, RX_ZERO, arg0, xf3);
          STEP_W'(1): word = enc_load(RX_S1, RX_ZERO, arg1, xf3);
          default:    word = enc_store(RX_S0, RX_S1, 12'd0, sf3);
        endcase
      end else begin
        case (rel)
          STEP_W'(0): word = enc_load(RX_S0, RX_ZERO, arg1, xf3);
          STEP_W'(1): word = enc_load(RX_S0, RX_S0, 12'd0, sf3);
          default:    word = enc_store(RX_S0, RX_ZERO, arg0, xf3);
        endcase
      end
    end else if (step < tail_at) begin
      rel = step - INC_AT;
      case (rel)
        STEP_W'(0): word = enc_load(RX_S1, RX_ZERO, arg1, xf3);
        STEP_W'(1): word = enc_addi(RX_S1, RX_S1, 12'd1 << size);
        default:    word = enc_store(RX_S1, RX_ZERO, arg1, xf3);
      endcase
    end else begin
      rel = step - tail_at;
      case (rel)
        STEP_W'(0): word = enc_csrr(RX_S0, CSR_SCR0);
        STEP_W'(1): word = enc_csrr(RX_S1, CSR_SCR1);
        default:    word = OP_EBREAK;
      endcase
    end
  end
endmodule

// File: rtl/absmem_ctrl.sv
module absmem_ctrl
  import absmem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  err_e              err,
  input  logic              pinc_q,
  input  logic              exec_done,
  output logic              accept,
  output logic              emitting,
  output logic [STEP_W-1:0] step,
  output logic              done,
  output logic              busy,
  output logic              go,
  output err_e              cmderr
);
  typedef enum logic [1:0] {S_IDLE, S_EMIT, S_RUN} state_e;

  state_e            st_q, st_n;
  logic [STEP_W-1:0] step_q, step_n, last_step;
  logic              done_q, done_n, go_q, go_n;
  err_e              err_q, err_n;

  always_comb begin
    accept    = cmd_valid && (st_q == S_IDLE);
    last_step = pinc_q ? STEP_W'(SEQ_MAX - 1) : STEP_W'(SEQ_MAX - 4);
    st_n      = st_q;
    step_n    = step_q;
    done_n    = 1'b0;
    go_n      = go_q;
    err_n     = err_q;
    case (st_q)
      S_IDLE: if (accept) begin
        err_n  = err;
        step_n = '0;
        if (err == ERR_NONE) st_n = S_EMIT;
      end
      S_EMIT: begin
        step_n = step_q + STEP_W'(1);
        if (step_q == last_step) begin
          st_n   = S_RUN;
          done_n = 1'b1;
          go_n   = 1'b1;
        end
      end
      default: if (exec_done) begin
        st_n = S_IDLE;
        go_n = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      step_q <= '0;
      done_q <= 1'b0;
      go_q   <= 1'b0;
      err_q  <= ERR_NONE;
    end else begin
      st_q   <= st_n;
      step_q <= step_n;
      done_q <= done_n;
      go_q   <= go_n;
      err_q  <= err_n;
    end
  end

  assign emitting = (st_q == S_EMIT);
  assign step     = step_q;
  assign done     = done_q;
  assign busy     = (st_q == S_RUN);
  assign go       = go_q;
  assign cmderr   = err_q;

  AST_EMIT_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    emitting |-> !busy); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && go && cmderr == ERR_NONE)); // R10
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmderr != ERR_NONE) |-> !emitting); // R2
  AST_STEP_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (emitting && $past(emitting)) |-> (step == $past(step) + STEP_W'(1))); // R9
endmodule

// File: rtl/absmem_seq_gen.sv
module absmem_seq_gen
  import absmem_pkg::*;
#(
  parameter logic [11:0] DATA_BASE = 12'h380
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_size,
  input  logic              cmd_postinc,
  input  logic              cmd_virtual,
  input  logic              cmd_write,
  input  logic              hart_halted,
  input  logic [1:0]        xlen_code,
  input  logic              exec_done,
  output logic              buf_we,
  output logic [STEP_W-1:0] buf_idx,
  output logic [31:0]       buf_wdata,
  output logic              seq_done,
  output logic              busy,
  output logic              go,
  output logic [2:0]        cmderr
);
  err_e              chk_err, err_q;
  logic [1:0]        xlog_c, xlog_q, size_q;
  logic              write_q, pinc_q, accept, emitting;
  logic [STEP_W-1:0] step;

  absmem_check u_check (
    .halted(hart_halted), .virt(cmd_virtual), .size(cmd_size),
    .xlen_code(xlen_code), .err(chk_err), .xlen_log(xlog_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q  <= '0;
      write_q <= 1'b0;
      pinc_q  <= 1'b0;
      xlog_q  <= 2'd2;
    end else if (accept) begin
      size_q  <= cmd_size[1:0];
      write_q <= cmd_write;
      pinc_q  <= cmd_postinc;
      xlog_q  <= xlog_c;
    end
  end

  absmem_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .err(chk_err),
    .pinc_q(pinc_q), .exec_done(exec_done), .accept(accept),
    .emitting(emitting), .step(step), .done(seq_done), .busy(busy),
    .go(go), .cmderr(err_q)
  );

  absmem_encoder #(.DATA_BASE(DATA_BASE)) u_enc (
    .step(step), .is_write(write_q), .postinc(pinc_q), .size(size_q),
    .xlen_log(xlog_q), .word(buf_wdata)
  );

  assign buf_we  = emitting;
  assign buf_idx = step;
  assign cmderr  = err_q;

  AST_HALT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hart_halted) |=> (cmderr == 3'd4 && !buf_we)); // R2
  AST_VIRT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hart_halted && cmd_virtual) |=> (cmderr == 3'd2 && !buf_we)); // R3
  AST_FIRST_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_we) |-> (buf_idx == '0)); // R9
endmodule

// File: tb/sim_absmem_seq_gen.sv
module sim_absmem_seq_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_postinc = 1'b0, cmd_virtual = 1'b0, cmd_write = 1'b0;
  logic [2:0]  cmd_size = '0;
  logic        hart_halted = 1'b1, exec_done = 1'b0;
  logic [1:0]  xlen_code = 2'd2;
  logic        buf_we, seq_done, busy, go;
  logic [3:0]  buf_idx;
  logic [31:0] buf_wdata;
  logic [2:0]  cmderr;

  int checks = 0, fails = 0;
  bit we_allowed = 1'b0;
  bit finished = 1'b0;
  localparam int BASE = 'h380;

  always #5 clk = ~clk;

  absmem_seq_gen u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_size(cmd_size),
    .cmd_postinc(cmd_postinc), .cmd_virtual(cmd_virtual), .cmd_write(cmd_write),
    .hart_halted(hart_halted), .xlen_code(xlen_code), .exec_done(exec_done),
    .buf_we(buf_we), .buf_idx(buf_idx), .buf_wdata(buf_wdata),
    .seq_done(seq_done), .busy(busy), .go(go), .cmderr(cmderr)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  // per-clock monitor: no buffer write outside an expected program (R9, R2, R3, R11)
  always @(negedge clk) if (rst_n && !finished && !we_allowed)
    chk(buf_we == 1'b0, "R9 stray write", 32'(buf_we), 32'd0);

  // reference instruction builders, written from the instruction formats
  function automatic int unsigned mk_i(int imm, int rs, int f3, int rd, int opc);
    return ((imm & 'hfff) << 20) | (rs << 15) | (f3 << 12) | (rd << 7) | opc;
  endfunction
  function automatic int unsigned mk_s(int imm, int rs2, int rs1, int f3);
    return (((imm >> 5) & 'h7f) << 25) | (rs2 << 20) | (rs1 << 15) | (f3 << 12)
         | ((imm & 'h1f) << 7) | 'h23;
  endfunction

  task automatic build(input int sz, input bit wr, input bit pinc, input int xl,
                       ref logic [31:0] q[$]);
    int xb = xl / 8;
    int xf = (xl == 64) ? 3 : 2;
    int a0 = BASE, a1 = BASE + xb;
    q = {};
    q.push_back(mk_i('h7b2, 8, 1, 0, 'h73));              // R4
    q.push_back(mk_i('h7b3, 9, 1, 0, 'h73));              // R4
    if (wr) begin                                          // R6
      q.push_back(mk_i(a0, 0, xf, 8, 'h03));
      q.push_back(mk_i(a1, 0, xf, 9, 'h03));
      q.push_back(mk_s(0, 8, 9, sz));
    end else begin                                         // R5
      q.push_back(mk_i(a1, 0, xf, 8, 'h03));
      q.push_back(mk_i(0, 8, sz, 8, 'h03));
      q.push_back(mk_s(a0, 8, 0, xf));
    end
    if (pinc) begin                                        // R7
      q.push_back(mk_i(a1, 0, xf, 9, 'h03));
      q.push_back(mk_i(1 << sz, 9, 0, 9, 'h13));
      q.push_back(mk_s(a1, 9, 0, xf));
    end
    q.push_back(mk_i('h7b2, 0, 2, 8, 'h73));
    q.push_back(mk_i('h7b3, 0, 2, 9, 'h73));
    q.push_back(32'h0010_0073);
  endtask

  task automatic run_ok(input int sz, input bit wr, input bit pinc, input int xl);
    logic [31:0] q[$];
    build(sz, wr, pinc, xl, q);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_size = 3'(sz); cmd_write = wr; cmd_postinc = pinc;
    cmd_virtual = 1'b0; hart_halted = 1'b1; xlen_code = (xl == 64) ? 2'd2 : 2'd1;
    @(posedge clk); we_allowed = 1'b1;
    @(negedge clk); cmd_valid = 1'b0;
    foreach (q[i]) begin
      chk(buf_we == 1'b1, "R9 write enable", 32'(buf_we), 32'd1);
      chk(buf_idx == 4'(i), "R9 index", 32'(buf_idx), i);
      chk(buf_wdata == q[i], "R4/R5/R6/R7/R8 word", buf_wdata, q[i]);
      if (i == q.size() - 1) begin @(posedge clk); we_allowed = 1'b0; end
      @(negedge clk);
    end
    chk(seq_done && busy && go, "R10 flags after last word", {seq_done, busy, go}, 3'b111);
    chk(cmderr == 3'd0, "R10 error cleared", 32'(cmderr), 0);
    @(negedge clk);
    chk(!seq_done && busy, "R10 single done pulse", {seq_done, busy}, 2'b01);
    cmd_valid = 1'b1; hart_halted = 1'b0;            // R11: must be ignored
    @(negedge clk); cmd_valid = 1'b0; hart_halted = 1'b1;
    chk(cmderr == 3'd0 && busy, "R11 command ignored while busy", {cmderr, busy}, 4'b0001);
    exec_done = 1'b1;
    @(negedge clk); exec_done = 1'b0;
    chk(!busy && !go, "R11 exec_done clears", {busy, go}, 2'b00);
  endtask

  task automatic run_bad(input int sz, input bit virt, input bit halted, input logic [1:0] xc,
                         input logic [2:0] exp, input string rq);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_size = sz[2:0]; cmd_virtual = virt; hart_halted = halted;
    xlen_code = xc; cmd_write = 1'b0; cmd_postinc = 1'b0;
    @(negedge clk); cmd_valid = 1'b0; cmd_virtual = 1'b0; hart_halted = 1'b1;
    chk(cmderr == exp, rq, 32'(cmderr), 32'(exp));
    chk(!busy && !go, {rq, " no start"}, {busy, go}, 2'b00);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!buf_we && !seq_done && !busy && !go && cmderr == 0, "R1 reset state",
        {buf_we, seq_done, busy, go, cmderr}, 0);
    run_ok(3, 1'b0, 1'b0, 64);   // R5 R12 doubleword read
    run_ok(0, 1'b1, 1'b1, 32);   // R6 R7 R12 byte write with increment
    run_ok(1, 1'b0, 1'b1, 32);   // R5 R7 halfword read
    run_ok(2, 1'b1, 1'b0, 64);   // R6 R8 word write on 64
    run_ok(0, 1'b0, 1'b1, 64);   // R7 R8 byte read with increment
    run_ok(3, 1'b1, 1'b1, 64);   // R7 doubleword step of 8
    run_bad(2, 1'b0, 1'b0, 2'd2, 3'd4, "R2 not halted");
    run_bad(3, 1'b1, 1'b0, 2'd1, 3'd4, "R2 halt check wins");
    run_bad(2, 1'b1, 1'b1, 2'd2, 3'd2, "R3 virtual");
    run_bad(3, 1'b0, 1'b1, 2'd1, 3'd2, "R3 size over XLEN 32");
    run_bad(4, 1'b0, 1'b1, 2'd2, 3'd2, "R3 size over 3");
    run_bad(0, 1'b0, 1'b1, 2'd3, 3'd2, "R3 bad xlen code");
    run_bad(0, 1'b0, 1'b1, 2'd0, 3'd2, "R3 xlen code zero");
    run_ok(2, 1'b0, 1'b0, 32);   // R10 error cleared by a good command
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule